// File: doc/BRIEF.md
# Encrypted Configuration Security Policy Controller

This block sits beside a device configuration engine and decides, one cycle at a time, whether a configuration-related request may go ahead. It tracks whether the design living in the device (or the one being loaded) came in as plaintext or encrypted. It applies stricter rules to the encrypted case: nothing may be read back, patched or warm-reloaded, and the configuration memory is wiped before an encrypted image goes in and again when that image is replaced. A load that fails its integrity check is also wiped.

Requests arrive as single-cycle strobes. The controller answers each serviced request with exactly one grant or deny pulse in the following cycle. It raises a configuration-clear command for a fixed number of cycles whenever a wipe is needed, and it enables the decryptor only while an encrypted image is streaming in. Any attempt to touch the keys is answered with a key-clear pulse and a full wipe, after which the controller is unconfigured. A 3-bit status code exposes the current mode.

Top module: `cfg_guard`

## Requirements
- R1: After reset the status is 0 (unconfigured) and grant, deny, key_clr, cfg_clr, busy and dec_en are all low.
- R2: The status code is 0 unconfigured, 1 clearing, 2 loading plaintext, 3 loading encrypted, 4 configured plaintext, 5 configured encrypted, 6 error.
- R3: Every cycle with at least one request strobe high is answered by exactly one pulse, grant or deny, in the next cycle. A cycle with no request strobe produces no pulse.
- R4: A full-load request with req_enc high is granted from states 0, 4, 5 or 6. It then holds cfg_clr and busy high for CLR_CYCLES cycles with status 1, after which the status becomes 3. dec_en is high exactly while the status is 3.
- R5: In state 3, a load-complete strobe with done_ok high moves to state 5. With done_ok low it starts a clear of CLR_CYCLES cycles that ends in state 6. A load-complete strobe outside states 2 and 3 changes nothing.
- R6: In states 3 and 5, readback, partial-load and warm-reconfiguration requests are denied and the status does not change.
- R7: A plaintext full load is granted from states 0, 4 or 6 and goes straight to state 2. Load-complete in state 2 gives state 4. In state 4, readback is granted with no state change, and partial-load and warm-reconfiguration requests are granted and enter state 2. In states 0 and 6, readback is denied.
- R8: A plaintext full load requested in state 5 is granted, clears for CLR_CYCLES cycles, then enters state 2.
- R9: A key-access request in any state is denied. In the cycle of the deny it pulses key_clr for one cycle and starts a clear of CLR_CYCLES cycles ending in state 0. A key request during a clear restarts the clear.
- R10: While a clear is in progress, every request other than key access is denied and load-complete strobes are ignored.
- R11: Requests to use the decryptor for user data are denied in every state.
- R12: In states 2 and 3, every request other than key access is denied and the state is unchanged.
- R13: When several request strobes are high together, only the highest in the order key, full load, warm reconfiguration, partial load, readback, decryptor use is judged. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_full | input | 1 | Full configuration load request strobe |
| req_enc | input | 1 | Qualifies req_full: 1 means the image is encrypted |
| req_part | input | 1 | Partial load request strobe |
| req_warm | input | 1 | Warm reconfiguration request strobe |
| req_rdbk | input | 1 | Configuration readback request strobe |
| req_key | input | 1 | Key access attempt strobe |
| req_dec | input | 1 | User-data decryptor use request strobe |
| done_stb | input | 1 | Load-complete strobe |
| done_ok | input | 1 | Integrity result with done_stb, 1 = pass |
| grant | output | 1 | One-cycle grant pulse |
| deny | output | 1 | One-cycle deny pulse |
| cfg_clr | output | 1 | Configuration memory clear command |
| key_clr | output | 1 | One-cycle key erase command |
| dec_en | output | 1 | Decryptor enable |
| busy | output | 1 | Clear sequence in progress |
| status | output | 3 | Mode code per R2 |

## Verification
A load-complete strobe can land in the same cycle as a request strobe. The hardest pairing is a key access arriving with load-complete during a plaintext load. The bench drives both on one edge and expects the key rule to win: a deny with key_clr, then a clear ending unconfigured, never the configured state. A load-complete strobe is also driven in the middle of a clear, and a second key strobe mid-clear. For each, the bench judges from the status code and the length of the cfg_clr window whether the strobe was ignored or restarted the wipe.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    typedef enum logic [2:0] {
        ST_UNCFG  = 3'd0,
        ST_CLEAR  = 3'd1,
        ST_LOAD_P = 3'd2,
        ST_LOAD_E = 3'd3,
        ST_CFG_P  = 3'd4,
        ST_CFG_E  = 3'd5,
        ST_ERR    = 3'd6
    } mode_e;

    typedef enum logic [2:0] {
        RQ_NONE = 3'd0,
        RQ_KEY  = 3'd1,
        RQ_FULL = 3'd2,
        RQ_WARM = 3'd3,
        RQ_PART = 3'd4,
        RQ_RDBK = 3'd5,
        RQ_DEC  = 3'd6
    } rq_e;

    localparam int NUM_RQ = 6;

    // Index 0 is highest priority.
    typedef struct packed {
        logic dec;
        logic rdbk;
        logic part;
        logic warm;
        logic full;
        logic key;
    } rq_vec_t;

    typedef struct packed {
        logic grant;
        logic deny;
        logic key_clr;
    } resp_t;

    function automatic rq_e rq_of_index(input int idx);
        case (idx)
            0:       return RQ_KEY;
            1:       return RQ_FULL;
            2:       return RQ_WARM;
            3:       return RQ_PART;
            4:       return RQ_RDBK;
            5:       return RQ_DEC;
            default: return RQ_NONE;
        endcase
    endfunction

    function automatic logic is_loading(input mode_e m);
        return (m == ST_LOAD_P) || (m == ST_LOAD_E);
    endfunction

    function automatic logic may_start_full(input mode_e m);
        return (m == ST_UNCFG) || (m == ST_CFG_P) || (m == ST_CFG_E) || (m == ST_ERR);
    endfunction

endpackage

// File: rtl/cfg_guard_arb.sv
module cfg_guard_arb
    import cfg_guard_pkg::*;
(
    input  rq_vec_t reqs,
    output rq_e     pick
);
    logic [NUM_RQ-1:0] raw;
    logic [NUM_RQ-1:0] higher;

    assign raw = reqs;

    // higher[i] is set when some strobe of greater priority than i is high
    genvar gi;
    generate
        for (gi = 0; gi < NUM_RQ; gi++) begin : g_chain
            if (gi == 0) begin : g_top
                assign higher[gi] = 1'b0;
            end else begin : g_rest
                assign higher[gi] = higher[gi-1] | raw[gi-1];
            end
        end
    endgenerate

    always_comb begin
        pick = RQ_NONE;
        for (int i = 0; i < NUM_RQ; i++) begin
            if (raw[i] && !higher[i]) begin
                pick = rq_of_index(i);
            end
        end
    end
endmodule

// File: rtl/cfg_guard_clr.sv
module cfg_guard_clr #(
    parameter int CLR_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active,
    output logic last
);
    localparam int CNT_W = $clog2(CLR_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CLR_CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD_VAL;
        end else if (cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign active = (cnt != '0);
    assign last   = (cnt == ONE);
endmodule

// File: rtl/cfg_guard_fsm.sv
module cfg_guard_fsm
    import cfg_guard_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rq_e   pick,
    input  logic  enc_sel,
    input  logic  done_stb,
    input  logic  done_ok,
    input  logic  clr_last,
    output mode_e state,
    output resp_t resp,
    output logic  clr_start
);
    mode_e state_n;
    mode_e target, target_n;
    resp_t resp_n;

    always_comb begin
        state_n   = state;
        target_n  = target;
        resp_n    = '0;
        clr_start = 1'b0;

        if (pick == RQ_KEY) begin
            resp_n.deny    = 1'b1;
            resp_n.key_clr = 1'b1;
            clr_start      = 1'b1;
            state_n        = ST_CLEAR;
            target_n       = ST_UNCFG;
        end else if (state == ST_CLEAR) begin
            resp_n.deny = (pick != RQ_NONE);
            if (clr_last) begin
                state_n = target;
            end
        end else begin
            case (pick)
                RQ_FULL: begin
                    if (may_start_full(state)) begin
                        resp_n.grant = 1'b1;
                        if (enc_sel || state == ST_CFG_E) begin
                            clr_start = 1'b1;
                            state_n   = ST_CLEAR;
                            target_n  = enc_sel ? ST_LOAD_E : ST_LOAD_P;
                        end else begin
                            state_n = ST_LOAD_P;
                        end
                    end else begin
                        resp_n.deny = 1'b1;
                    end
                end
                RQ_WARM, RQ_PART: begin
                    if (state == ST_CFG_P) begin
                        resp_n.grant = 1'b1;
                        state_n      = ST_LOAD_P;
                    end else begin
                        resp_n.deny = 1'b1;
                    end
                end
                RQ_RDBK: begin
                    resp_n.grant = (state == ST_CFG_P);
                    resp_n.deny  = (state != ST_CFG_P);
                end
                RQ_DEC: begin
                    resp_n.deny = 1'b1;
                end
                default: begin
                end
            endcase

            // Requests never move a loading state, so completion is independent.
            if (done_stb && is_loading(state)) begin
                if (state == ST_LOAD_P) begin
                    state_n = ST_CFG_P;
                end else if (done_ok) begin
                    state_n = ST_CFG_E;
                end else begin
                    clr_start = 1'b1;
                    state_n   = ST_CLEAR;
                    target_n  = ST_ERR;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_UNCFG;
            target <= ST_UNCFG;
            resp   <= '0;
        end else begin
            state  <= state_n;
            target <= target_n;
            resp   <= resp_n;
        end
    end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int CLR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_full,
    input  logic       req_enc,
    input  logic       req_part,
    input  logic       req_warm,
    input  logic       req_rdbk,
    input  logic       req_key,
    input  logic       req_dec,
    input  logic       done_stb,
    input  logic       done_ok,
    output logic       grant,
    output logic       deny,
    output logic       cfg_clr,
    output logic       key_clr,
    output logic       dec_en,
    output logic       busy,
    output logic [2:0] status
);
    rq_vec_t reqs;
    rq_e     pick;
    mode_e   state;
    resp_t   resp;
    logic    clr_start;
    logic    clr_active;
    logic    clr_last;

    assign reqs = '{dec: req_dec, rdbk: req_rdbk, part: req_part,
                    warm: req_warm, full: req_full, key: req_key};

    cfg_guard_arb u_arb (
        .reqs (reqs),
        .pick (pick)
    );

    cfg_guard_clr #(.CLR_CYCLES(CLR_CYCLES)) u_clr (
        .clk    (clk),
        .rst    (rst),
        .start  (clr_start),
        .active (clr_active),
        .last   (clr_last)
    );

    cfg_guard_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pick      (pick),
        .enc_sel   (req_enc),
        .done_stb  (done_stb),
        .done_ok   (done_ok),
        .clr_last  (clr_last),
        .state     (state),
        .resp      (resp),
        .clr_start (clr_start)
    );

    assign grant   = resp.grant;
    assign deny    = resp.deny;
    assign key_clr = resp.key_clr;
    assign cfg_clr = clr_active;
    assign busy    = clr_active;
    assign dec_en  = (state == ST_LOAD_E);
    assign status  = state;
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_full,
    input logic       req_part,
    input logic       req_warm,
    input logic       req_rdbk,
    input logic       req_key,
    input logic       req_dec,
    input logic       grant,
    input logic       deny,
    input logic       cfg_clr,
    input logic       key_clr,
    input logic       dec_en,
    input logic       busy,
    input logic [2:0] status
);
    logic any_req;
    logic rdbk_top;
    logic dec_only;

    assign any_req  = req_full | req_part | req_warm | req_rdbk | req_key | req_dec;
    assign rdbk_top = req_rdbk & ~req_key & ~req_full & ~req_warm & ~req_part;
    assign dec_only = req_dec & ~req_rdbk & ~req_key & ~req_full & ~req_warm & ~req_part;

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        !(grant && deny)); // R3

    AST_RESPONSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        any_req |=> (grant || deny)); // R3

    AST_KEY_WIPES: assert property (@(posedge clk) disable iff (rst)
        key_clr |-> (deny && cfg_clr && status == 3'd1)); // R9

    AST_CLEAR_BUSY: assert property (@(posedge clk) disable iff (rst)
        cfg_clr |-> (busy && status == 3'd1)); // R10

    AST_ENC_LOAD_WIPED: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_en) |-> $past(cfg_clr)); // R4

    AST_NO_RDBK_ENC: assert property (@(posedge clk) disable iff (rst)
        (rdbk_top && (status == 3'd3 || status == 3'd5)) |=> (deny && !grant)); // R6

    AST_ENC_CFG_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        (status == 3'd5 && $past(status) != 3'd5) |-> $past(status) == 3'd3); // R5

    AST_NO_USER_DECRYPT: assert property (@(posedge clk) disable iff (rst)
        dec_only |=> !grant); // R11
endmodule

bind cfg_guard cfg_guard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_full (req_full),
    .req_part (req_part),
    .req_warm (req_warm),
    .req_rdbk (req_rdbk),
    .req_key  (req_key),
    .req_dec  (req_dec),
    .grant    (grant),
    .deny     (deny),
    .cfg_clr  (cfg_clr),
    .key_clr  (key_clr),
    .dec_en   (dec_en),
    .busy     (busy),
    .status   (status)
);

// File: tb/cfg_guard_test.sv
`timescale 1ns/1ps
module cfg_guard_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_full = 0, req_enc = 0, req_part = 0, req_warm = 0;
    logic req_rdbk = 0, req_key = 0, req_dec = 0, done_stb = 0, done_ok = 0;
    logic grant, deny, cfg_clr, key_clr, dec_en, busy;
    logic [2:0] status;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // request bit order: {key, full, warm, part, rdbk, dec}
    localparam logic [5:0] NO = 6'b000000, K = 6'b100000, F = 6'b010000,
                           W = 6'b001000, P = 6'b000100, RB = 6'b000010, DC = 6'b000001;
    localparam logic [2:0] S_UN = 3'd0, S_CL = 3'd1, S_LP = 3'd2, S_LE = 3'd3,
                           S_CP = 3'd4, S_CE = 3'd5, S_ER = 3'd6;

    // expected bits {grant, deny, key_clr, cfg_clr, busy, dec_en, status}
    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    cfg_guard uut (
        .clk(clk), .rst(rst), .req_full(req_full), .req_enc(req_enc),
        .req_part(req_part), .req_warm(req_warm), .req_rdbk(req_rdbk),
        .req_key(req_key), .req_dec(req_dec), .done_stb(done_stb),
        .done_ok(done_ok), .grant(grant), .deny(deny), .cfg_clr(cfg_clr),
        .key_clr(key_clr), .dec_en(dec_en), .busy(busy), .status(status)
    );

    task automatic cyc(input logic [5:0] rq, input logic enc, input logic dn,
                       input logic ok, input logic eg, input logic ed,
                       input logic ekc, input logic eclr, input logic [2:0] est,
                       input string tag);
        {req_key, req_full, req_warm, req_part, req_rdbk, req_dec} = rq;
        req_enc  = enc;
        done_stb = dn;
        done_ok  = ok;
        @(posedge clk);
        exp_q.push_back({eg, ed, ekc, eclr, eclr, (est == S_LE), est});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic req(input logic [5:0] rq, input logic enc, input logic eg,
                       input logic ed, input logic ekc, input logic eclr,
                       input logic [2:0] est, input string tag);
        cyc(rq, enc, 1'b0, 1'b0, eg, ed, ekc, eclr, est, tag);
    endtask

    task automatic idle(input logic eclr, input logic [2:0] est, input string tag);
        cyc(NO, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, eclr, est, tag);
    endtask

    task automatic fin(input logic ok, input logic eclr, input logic [2:0] est,
                       input string tag);
        cyc(NO, 1'b0, 1'b1, ok, 1'b0, 1'b0, 1'b0, eclr, est, tag);
    endtask

    // monitor: compares each expected item one half cycle after its edge
    always @(negedge clk) begin
        if (!finished && exp_q.size() > 0) begin
            logic [8:0] e;
            logic [8:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {grant, deny, key_clr, cfg_clr, busy, dec_en, status};
            n_cmp++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s: got g/d/kc/clr/busy/dec/st=%b expected %b", t, a, e);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        idle(0, S_UN, "R1");
        req(RB, 0, 0, 1, 0, 0, S_UN, "R7");
        req(DC, 0, 0, 1, 0, 0, S_UN, "R11");
        fin(1, 0, S_UN, "R5");
        // plaintext life cycle, status codes per R2
        req(F, 0, 1, 0, 0, 0, S_LP, "R7");
        req(RB, 0, 0, 1, 0, 0, S_LP, "R12");
        req(F, 1, 0, 1, 0, 0, S_LP, "R12");
        fin(1, 0, S_CP, "R7");
        req(RB, 0, 1, 0, 0, 0, S_CP, "R7");
        req(W, 0, 1, 0, 0, 0, S_LP, "R7");
        fin(1, 0, S_CP, "R2");
        req(P, 0, 1, 0, 0, 0, S_LP, "R7");
        fin(1, 0, S_CP, "R7");
        req(W | RB, 0, 1, 0, 0, 0, S_LP, "R13");
        fin(1, 0, S_CP, "R13");
        req(RB | DC, 0, 1, 0, 0, 0, S_CP, "R13");
        idle(0, S_CP, "R3");
        // encrypted load with a wipe first
        req(F, 1, 1, 0, 0, 1, S_CL, "R4");
        req(RB, 0, 0, 1, 0, 1, S_CL, "R10");
        fin(1, 1, S_CL, "R10");
        idle(1, S_CL, "R4");
        idle(0, S_LE, "R4");
        req(RB, 0, 0, 1, 0, 0, S_LE, "R6");
        req(W, 0, 0, 1, 0, 0, S_LE, "R12");
        fin(1, 0, S_CE, "R5");
        req(RB, 0, 0, 1, 0, 0, S_CE, "R6");
        req(P, 0, 0, 1, 0, 0, S_CE, "R6");
        req(W, 0, 0, 1, 0, 0, S_CE, "R6");
        req(DC, 0, 0, 1, 0, 0, S_CE, "R11");
        // replacing encrypted with plaintext
        req(F, 0, 1, 0, 0, 1, S_CL, "R8");
        for (int i = 0; i < 3; i++) idle(1, S_CL, "R8");
        idle(0, S_LP, "R8");
        fin(1, 0, S_CP, "R8");
        // key attempt beats readback
        req(K | RB, 0, 0, 1, 1, 1, S_CL, "R9");
        for (int i = 0; i < 3; i++) idle(1, S_CL, "R9");
        idle(0, S_UN, "R9");
        // encrypted load failing integrity
        req(F, 1, 1, 0, 0, 1, S_CL, "R4");
        for (int i = 0; i < 3; i++) idle(1, S_CL, "R4");
        idle(0, S_LE, "R4");
        fin(0, 1, S_CL, "R5");
        for (int i = 0; i < 3; i++) idle(1, S_CL, "R5");
        idle(0, S_ER, "R5");
        req(RB, 0, 0, 1, 0, 0, S_ER, "R7");
        req(F, 0, 1, 0, 0, 0, S_LP, "R7");
        // key together with load-complete, then a key mid-clear
        cyc(K, 0, 1, 1, 0, 1, 1, 1, S_CL, "R9");
        idle(1, S_CL, "R9");
        idle(1, S_CL, "R9");
        req(K, 0, 0, 1, 1, 1, S_CL, "R9");
        for (int i = 0; i < 3; i++) idle(1, S_CL, "R9");
        idle(0, S_UN, "R9");
        idle(0, S_UN, "R3");

        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule